// File: doc/BRIEF.md
# System Control Register Block

This block is a bank of 16-bit control and status registers on a simple single-cycle peripheral bus. Software reaches it through byte offsets that step in halfwords. It carries the board identity, two indicator LEDs and a bit-banged two-wire port for a real-time clock. It also holds three general-purpose pin banks with per-pin direction, a random word that is refreshed once per second, a PLL phase field, a small scratch field, three strap bits captured when reset is released, and a reset-switch enable that can raise a reboot request.

Pads are modelled as separate input, output and output-enable vectors. All pad inputs pass through a two-flop synchroniser before software or logic sees them. A read is requested by holding `busSel` high with `busWr` low for one cycle. The data appears on `busRdata` together with `busRvalid` on the next cycle. A write takes effect at the clock edge that samples it.

GPIO vector layout: bits [15:0] are pins 5..20, bits [31:16] are pins 21..36 and bits [35:32] are pins 37..40, with the lower pin number at the lower bit.

Top module: `sysctl_regs`

## Requirements
- R1: A read strobe yields `busRvalid`=1 with the data on the following cycle, and `busRvalid` is 0 otherwise. Offsets 0x14 and 0x18..0x1E read as 0, and writes to them change nothing. Address bit 0 is ignored.
- R2: Offset 0x0 reads the model identifier 0x7500. Offset 0x2 bits 7:4 read the submodel (default 0) and bits 3:0 read the revision (default 3). Writes to any of these change nothing.
- R3: At offset 0x2, bit 15 drives `ledGreen` and bit 14 drives `ledRed` (1 = on). The RTC clock line uses input in bit 13, direction in bit 11 and output in bit 9. The RTC data line uses input in bit 12, direction in bit 10 and output in bit 8. The input bits are read-only.
- R4: Offset 0x4 reads a word that loads `randIn` on each cycle `secTick` is 1 and holds it at all other times.
- R5: Pins 21..36 (`gpio*[31:16]`) use offset 0x8 for the read-only input, 0xA for the output and 0xC for the direction.
- R6: Pins 5..20 (`gpio*[15:0]`) use offset 0xE for the read-only input, 0x10 for the output and 0x12 for the direction.
- R7: Offset 0x6 packs pins 37..40 (`gpio*[35:32]`): input in bits 15:12 (read-only), output in 11:8 and direction in 7:4. Bits 3..0 are the tag-memory clock, serial-in, active-low chip-select and read-only serial-out.
- R8: Each output-enable bit equals its direction bit (1 = output). Input fields return the synchronised pad value, which is visible within three cycles of a pad change, and ignore written data.
- R9: At offset 0x16, bits 10:6 are the PLL phase driven on `pllPhase` and bits 3:2 are scratch. Bits 15:11 always read 0 and ignore writes.
- R10: Offset 0x16 bits 5, 1 and 0 read `strapIn[2]`, `strapIn[1]` and `strapIn[0]` as sampled at the first clock edge after reset release. They hold until the next reset and ignore writes.
- R11: Offset 0x16 bit 4 enables the reset switch. `rebootReq` is 1 exactly when it is set and synchronised pin 9 (`gpioIn[4]`) is 0.
- R12: After reset, every writable field is 0 except the tag chip-select (offset 0x6 bit 1), which is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Access request |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 5 | Byte offset |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data |
| busRvalid | output | 1 | Read data valid |
| gpioIn | input | 36 | Pad inputs |
| gpioOut | output | 36 | Pad output values |
| gpioOe | output | 36 | Pad output enables |
| rtcSclIn | input | 1 | RTC clock pad input |
| rtcSdaIn | input | 1 | RTC data pad input |
| rtcSclOut | output | 1 | RTC clock output value |
| rtcSdaOut | output | 1 | RTC data output value |
| rtcSclOe | output | 1 | RTC clock output enable |
| rtcSdaOe | output | 1 | RTC data output enable |
| ledGreen | output | 1 | Green LED |
| ledRed | output | 1 | Red LED |
| tagClk | output | 1 | Tag memory clock |
| tagSi | output | 1 | Tag memory serial in |
| tagCsN | output | 1 | Tag memory chip select, active low |
| tagSo | input | 1 | Tag memory serial out |
| randIn | input | 16 | Random source |
| secTick | input | 1 | One-second refresh pulse |
| strapIn | input | 3 | Bootstrap straps |
| pllPhase | output | 5 | PLL phase field |
| rebootReq | output | 1 | Reboot request |

## Verification
Most state in this block is mirrored straight onto output pins. A wrong register value therefore shows on `gpioOut`, `gpioOe`, the LED, RTC and tag pins or `pllPhase` one cycle after the write that sets it. Read-only and reserved fields that take a write, and strap bits that drift after reset, only show through a later read. The bench therefore reads every such field back after writing all-ones over it. A wrong decode shows on `busRdata` in the cycle after the read strobe. It can show as data from a neighbouring offset, or as a write landing in another register, which a later readback exposes.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  typedef enum logic [3:0] {
    RS_ID, RS_CTRL, RS_RAND, RS_MISC,
    RS_AIN, RS_AOUT, RS_ADIR,
    RS_BIN, RS_BOUT, RS_BDIR,
    RS_CFG, RS_NONE
  } regSel_e;

  typedef struct packed {
    logic    rdEn;
    logic    wrEn;
    regSel_e sel;
  } busStrobe_t;
endpackage

// File: rtl/sysctl_sync.sv
module sysctl_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stageQ [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : gStage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stageQ[s] <= '0;
      else if (s == 0) stageQ[s] <= din;
      else stageQ[s] <= stageQ[(s == 0) ? 0 : s-1];
    end
  end

  assign dout = stageQ[STAGES-1];
endmodule

// File: rtl/sysctl_ctrl.sv
module sysctl_ctrl
  import sysctl_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output busStrobe_t        strb
);
  localparam int IDX_W = ADDR_W - 1;
  logic [IDX_W-1:0] halfIdx;

  assign halfIdx = busAddr[ADDR_W-1:1];

  always_comb begin
    strb.rdEn = busSel && !busWr;
    strb.wrEn = busSel && busWr;
    unique case (halfIdx)
      4'h0:    strb.sel = RS_ID;
      4'h1:    strb.sel = RS_CTRL;
      4'h2:    strb.sel = RS_RAND;
      4'h3:    strb.sel = RS_MISC;
      4'h4:    strb.sel = RS_AIN;
      4'h5:    strb.sel = RS_AOUT;
      4'h6:    strb.sel = RS_ADIR;
      4'h7:    strb.sel = RS_BIN;
      4'h8:    strb.sel = RS_BOUT;
      4'h9:    strb.sel = RS_BDIR;
      4'hB:    strb.sel = RS_CFG;
      default: strb.sel = RS_NONE;
    endcase
  end
endmodule

// File: rtl/sysctl_dp.sv
module sysctl_dp
  import sysctl_pkg::*;
#(
  parameter int          BANK_W     = 16,
  parameter int          TOP_W      = 4,
  parameter int          SYNC_STG   = 2,
  parameter logic [15:0] MODEL_ID   = 16'h7500,
  parameter logic [3:0]  SUBMODEL   = 4'h0,
  parameter logic [3:0]  REVISION   = 4'h3,
  parameter int          RST_PIN    = 4,
  localparam int         GPIO_W     = 2*BANK_W + TOP_W,
  localparam int         SYNC_W     = GPIO_W + 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStrobe_t        strb,
  input  logic [15:0]       wdata,
  output logic [15:0]       rdata,
  output logic              rvalid,
  input  logic [GPIO_W-1:0] gpioIn,
  output logic [GPIO_W-1:0] gpioOut,
  output logic [GPIO_W-1:0] gpioOe,
  input  logic              rtcSclIn,
  input  logic              rtcSdaIn,
  output logic              rtcSclOut,
  output logic              rtcSdaOut,
  output logic              rtcSclOe,
  output logic              rtcSdaOe,
  output logic              ledGreen,
  output logic              ledRed,
  output logic              tagClk,
  output logic              tagSi,
  output logic              tagCsN,
  input  logic              tagSo,
  input  logic [15:0]       randIn,
  input  logic              secTick,
  input  logic [2:0]        strapIn,
  output logic [4:0]        pllPhase,
  output logic              rebootReq
);
  localparam int LO  = 0;
  localparam int HI  = BANK_W;
  localparam int TOP = 2*BANK_W;

  logic [SYNC_W-1:0] syncIn;
  logic [GPIO_W-1:0] padSync;
  logic              sclSync, sdaSync, soSync;

  sysctl_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STG)) uSync (
    .clk (clk),
    .rstN(rstN),
    .din ({tagSo, rtcSclIn, rtcSdaIn, gpioIn}),
    .dout(syncIn)
  );
  assign padSync = syncIn[GPIO_W-1:0];
  assign sdaSync = syncIn[GPIO_W];
  assign sclSync = syncIn[GPIO_W+1];
  assign soSync  = syncIn[GPIO_W+2];

  logic [GPIO_W-1:0] outQ, dirQ;
  logic [1:0]  ledQ;     // [1] green, [0] red
  logic [1:0]  rtcDirQ;  // [1] scl, [0] sda
  logic [1:0]  rtcOutQ;
  logic [2:0]  tagQ;     // [2] clk, [1] si, [0] csN
  logic [4:0]  pllQ;
  logic [1:0]  scratchQ;
  logic        swEnQ;
  logic [2:0]  strapQ;
  logic        strapOpen;
  logic [15:0] randQ;
  logic [15:0] rdMux;
  logic        wrCtrl, wrMisc, wrAOut, wrADir, wrBOut, wrBDir, wrCfg;

  assign wrCtrl = strb.wrEn && strb.sel == RS_CTRL;
  assign wrMisc = strb.wrEn && strb.sel == RS_MISC;
  assign wrAOut = strb.wrEn && strb.sel == RS_AOUT;
  assign wrADir = strb.wrEn && strb.sel == RS_ADIR;
  assign wrBOut = strb.wrEn && strb.sel == RS_BOUT;
  assign wrBDir = strb.wrEn && strb.sel == RS_BDIR;
  assign wrCfg  = strb.wrEn && strb.sel == RS_CFG;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outQ     <= '0;
      dirQ     <= '0;
      ledQ     <= '0;
      rtcDirQ  <= '0;
      rtcOutQ  <= '0;
      tagQ     <= 3'b001;
      pllQ     <= '0;
      scratchQ <= '0;
      swEnQ    <= 1'b0;
    end else begin
      if (wrCtrl) begin
        ledQ    <= wdata[15:14];
        rtcDirQ <= wdata[11:10];
        rtcOutQ <= wdata[9:8];
      end
      if (wrMisc) begin
        outQ[TOP +: TOP_W] <= wdata[11:8];
        dirQ[TOP +: TOP_W] <= wdata[7:4];
        tagQ               <= wdata[3:1];
      end
      if (wrAOut) outQ[HI +: BANK_W] <= wdata[BANK_W-1:0];
      if (wrADir) dirQ[HI +: BANK_W] <= wdata[BANK_W-1:0];
      if (wrBOut) outQ[LO +: BANK_W] <= wdata[BANK_W-1:0];
      if (wrBDir) dirQ[LO +: BANK_W] <= wdata[BANK_W-1:0];
      if (wrCfg) begin
        pllQ     <= wdata[10:6];
        swEnQ    <= wdata[4];
        scratchQ <= wdata[3:2];
      end
    end
  end

  // straps: open through reset, captured on first edge after release
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strapOpen <= 1'b1;
      strapQ    <= '0;
    end else if (strapOpen) begin
      strapOpen <= 1'b0;
      strapQ    <= strapIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        randQ <= '0;
    else if (secTick) randQ <= randIn;
  end

  always_comb begin
    rdMux = '0;
    unique case (strb.sel)
      RS_ID:   rdMux = MODEL_ID;
      RS_CTRL: rdMux = {ledQ, sclSync, sdaSync, rtcDirQ, rtcOutQ, SUBMODEL, REVISION};
      RS_RAND: rdMux = randQ;
      RS_MISC: rdMux = {padSync[TOP +: TOP_W], outQ[TOP +: TOP_W],
                        dirQ[TOP +: TOP_W], tagQ, soSync};
      RS_AIN:  rdMux = padSync[HI +: BANK_W];
      RS_AOUT: rdMux = outQ[HI +: BANK_W];
      RS_ADIR: rdMux = dirQ[HI +: BANK_W];
      RS_BIN:  rdMux = padSync[LO +: BANK_W];
      RS_BOUT: rdMux = outQ[LO +: BANK_W];
      RS_BDIR: rdMux = dirQ[LO +: BANK_W];
      RS_CFG:  rdMux = {5'b0, pllQ, strapQ[2], swEnQ, scratchQ, strapQ[1:0]};
      default: rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= strb.rdEn;
      rdata  <= strb.rdEn ? rdMux : '0;
    end
  end

  assign gpioOut   = outQ;
  assign gpioOe    = dirQ;
  assign ledGreen  = ledQ[1];
  assign ledRed    = ledQ[0];
  assign rtcSclOe  = rtcDirQ[1];
  assign rtcSdaOe  = rtcDirQ[0];
  assign rtcSclOut = rtcOutQ[1];
  assign rtcSdaOut = rtcOutQ[0];
  assign tagClk    = tagQ[2];
  assign tagSi     = tagQ[1];
  assign tagCsN    = tagQ[0];
  assign pllPhase  = pllQ;
  assign rebootReq = swEnQ && !padSync[RST_PIN];
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
#(
  parameter int          ADDR_W   = 5,
  parameter int          BANK_W   = 16,
  parameter int          TOP_W    = 4,
  parameter int          SYNC_STG = 2,
  parameter logic [15:0] MODEL_ID = 16'h7500,
  parameter logic [3:0]  SUBMODEL = 4'h0,
  parameter logic [3:0]  REVISION = 4'h3,
  parameter int          RST_PIN  = 4,
  localparam int         GPIO_W   = 2*BANK_W + TOP_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [15:0]       busWdata,
  output logic [15:0]       busRdata,
  output logic              busRvalid,
  input  logic [GPIO_W-1:0] gpioIn,
  output logic [GPIO_W-1:0] gpioOut,
  output logic [GPIO_W-1:0] gpioOe,
  input  logic              rtcSclIn,
  input  logic              rtcSdaIn,
  output logic              rtcSclOut,
  output logic              rtcSdaOut,
  output logic              rtcSclOe,
  output logic              rtcSdaOe,
  output logic              ledGreen,
  output logic              ledRed,
  output logic              tagClk,
  output logic              tagSi,
  output logic              tagCsN,
  input  logic              tagSo,
  input  logic [15:0]       randIn,
  input  logic              secTick,
  input  logic [2:0]        strapIn,
  output logic [4:0]        pllPhase,
  output logic              rebootReq
);
  busStrobe_t strb;

  sysctl_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .busSel (busSel),
    .busWr  (busWr),
    .busAddr(busAddr),
    .strb   (strb)
  );

  sysctl_dp #(
    .BANK_W(BANK_W), .TOP_W(TOP_W), .SYNC_STG(SYNC_STG),
    .MODEL_ID(MODEL_ID), .SUBMODEL(SUBMODEL), .REVISION(REVISION),
    .RST_PIN(RST_PIN)
  ) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .wdata(busWdata),
    .rdata(busRdata), .rvalid(busRvalid),
    .gpioIn(gpioIn), .gpioOut(gpioOut), .gpioOe(gpioOe),
    .rtcSclIn(rtcSclIn), .rtcSdaIn(rtcSdaIn),
    .rtcSclOut(rtcSclOut), .rtcSdaOut(rtcSdaOut),
    .rtcSclOe(rtcSclOe), .rtcSdaOe(rtcSdaOe),
    .ledGreen(ledGreen), .ledRed(ledRed),
    .tagClk(tagClk), .tagSi(tagSi), .tagCsN(tagCsN), .tagSo(tagSo),
    .randIn(randIn), .secTick(secTick), .strapIn(strapIn),
    .pllPhase(pllPhase), .rebootReq(rebootReq)
  );
endmodule

// File: rtl/sysctl_chk.sv
module sysctl_chk #(
  parameter int          ADDR_W   = 5,
  parameter int          GPIO_W   = 36,
  parameter int          BANK_W   = 16,
  parameter logic [15:0] MODEL_ID = 16'h7500
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [15:0]       busWdata,
  input logic [15:0]       busRdata,
  input logic              busRvalid,
  input logic [GPIO_W-1:0] gpioOe,
  input logic [4:0]        pllPhase
);
  logic rdReq, wrReq;
  logic [ADDR_W-2:0] idx;
  assign rdReq = busSel && !busWr;
  assign wrReq = busSel && busWr;
  assign idx   = busAddr[ADDR_W-1:1];

  AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |=> busRvalid);  // R1
  AST_NO_SPURIOUS_RVALID: assert property (@(posedge clk) disable iff (!rstN)
    !rdReq |=> !busRvalid);  // R1
  AST_ID_VALUE: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && idx == 0) |=> busRdata == MODEL_ID);  // R2
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && idx == 4'hB) |=> busRdata[15:11] == 5'b0);  // R9
  AST_PLL_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (wrReq && idx == 4'hB) |=> pllPhase == $past(busWdata[10:6]));  // R9
  AST_HIGH_BANK_DIR: assert property (@(posedge clk) disable iff (!rstN)
    (wrReq && idx == 4'h6) |=> gpioOe[2*BANK_W-1:BANK_W] == $past(busWdata));  // R5
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && (idx == 4'hA || idx > 4'hB)) |=> busRdata == 16'h0);  // R1
endmodule

bind sysctl_regs sysctl_chk #(
  .ADDR_W(ADDR_W), .GPIO_W(GPIO_W), .BANK_W(BANK_W), .MODEL_ID(MODEL_ID)
) uChk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
  .busWdata(busWdata), .busRdata(busRdata), .busRvalid(busRvalid),
  .gpioOe(gpioOe), .pllPhase(pllPhase)
);

// File: tb/tb_sysctl_regs.sv
module tb_sysctl_regs;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWr = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic        busRvalid;
  logic [35:0] gpioIn = '0;
  logic [35:0] gpioOut, gpioOe;
  logic        rtcSclIn = 1'b1, rtcSdaIn = 1'b0;
  logic        rtcSclOut, rtcSdaOut, rtcSclOe, rtcSdaOe;
  logic        ledGreen, ledRed, tagClk, tagSi, tagCsN;
  logic        tagSo = 1'b1;
  logic [15:0] randIn = 16'h1234;
  logic        secTick = 1'b0;
  logic [2:0]  strapIn = 3'b101;
  logic [4:0]  pllPhase;
  logic        rebootReq;

  int vecCnt = 0;
  int errCnt = 0;
  logic [15:0] expQ[$];
  string       tagQ[$];
  bit          done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  sysctl_regs dut (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    vecCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(input logic [4:0] a, input logic [15:0] exp, input string req);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    expQ.push_back(exp);
    tagQ.push_back(req);
    @(negedge clk);
    busSel = 1'b0;
  endtask

  // monitor: pops expected items as read data appears
  always @(negedge clk) begin
    if (rstN && busRvalid) begin
      if (expQ.size() == 0) check("R1 unexpected rvalid", 1, 0);
      else check(tagQ.pop_front(), busRdata, expQ.pop_front());
    end
  end

  initial begin
    #3;
    check("R12 rvalid in reset", busRvalid, 0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    strapIn = 3'b010;  // later changes must not show
    // R12 reset state
    check("R12 oe", gpioOe, 0);
    check("R12 out", gpioOut, 0);
    check("R12 csN", {tagCsN, tagClk, tagSi, ledGreen, ledRed}, 5'b10000);
    check("R12 reboot", rebootReq, 0);
    // R2 identity
    busRead(5'h00, 16'h7500, "R2 id");
    busWrite(5'h00, 16'hFFFF);
    busRead(5'h01, 16'h7500, "R2 id after write, addr bit0");
    busRead(5'h02, 16'h2003, "R3/R2 ctrl reset");
    // R3 LEDs and RTC
    busWrite(5'h02, 16'hFFFF);
    check("R3 leds", {ledGreen, ledRed}, 2'b11);
    check("R3 rtc", {rtcSclOe, rtcSdaOe, rtcSclOut, rtcSdaOut}, 4'b1111);
    busRead(5'h02, 16'hEF03, "R3 ro bits kept");
    busWrite(5'h02, 16'h4500);
    check("R3 leds 2", {ledGreen, ledRed, rtcSclOe, rtcSdaOe, rtcSclOut, rtcSdaOut}, 6'b010101);
    // R4 random word
    busRead(5'h04, 16'h0000, "R4 before tick");
    @(negedge clk); secTick = 1'b1; @(negedge clk); secTick = 1'b0; randIn = 16'hBEEF;
    busRead(5'h04, 16'h1234, "R4 after tick holds");
    // R5/R6 banks
    gpioIn = 36'hA_C3C3_5A5A;
    busWrite(5'h0A, 16'h1357);
    busWrite(5'h0C, 16'hF00F);
    busWrite(5'h10, 16'h2468);
    busWrite(5'h12, 16'h0FF0);
    check("R8 oe mirrors dir", gpioOe, 36'h0_F00F_0FF0);
    check("R5 R6 out", gpioOut, 36'h0_1357_2468);
    busRead(5'h08, 16'hC3C3, "R5 input");
    busRead(5'h0E, 16'h5A5A, "R6 input");
    busWrite(5'h08, 16'h0000);
    busWrite(5'h0E, 16'h0000);
    busRead(5'h08, 16'hC3C3, "R8 input ignores write");
    busRead(5'h0A, 16'h1357, "R5 out read");
    busRead(5'h12, 16'h0FF0, "R6 dir read");
    // R8 synchroniser latency
    gpioIn[31:16] = 16'h0F0F;
    repeat (3) @(negedge clk);
    busRead(5'h08, 16'h0F0F, "R8 input latency");
    // R7 top bank and tag port
    busRead(5'h06, 16'hA003, "R7 misc reset");
    busWrite(5'h06, 16'hFFFF);
    check("R7 top out/oe", {gpioOut[35:32], gpioOe[35:32]}, 8'hFF);
    check("R7 tag pins", {tagClk, tagSi, tagCsN}, 3'b111);
    busWrite(5'h06, 16'h0538);
    busRead(5'h06, 16'hA539, "R7 misc fields");
    // R9/R10/R11 config
    busRead(5'h16, 16'h0021, "R10 straps latched");
    busWrite(5'h16, 16'hFFFF);
    check("R9 pll pin", pllPhase, 5'h1F);
    busRead(5'h16, 16'h07FD, "R9 R10 cfg all ones");
    gpioIn[4] = 1'b1;
    busWrite(5'h16, 16'h0290);
    repeat (3) @(negedge clk);
    check("R11 pin high no reboot", rebootReq, 0);
    gpioIn[4] = 1'b0;
    repeat (3) @(negedge clk);
    check("R11 reboot", rebootReq, 1);
    busWrite(5'h16, 16'h0000);
    check("R11 disabled", rebootReq, 0);
    // R1 unmapped
    busWrite(5'h14, 16'hFFFF);
    busWrite(5'h18, 16'hFFFF);
    busRead(5'h14, 16'h0000, "R1 unmapped 14");
    busRead(5'h1E, 16'h0000, "R1 unmapped 1E");
    busRead(5'h10, 16'h2468, "R1 no alias write");
    repeat (3) @(negedge clk);
    check("R1 queue drained", expQ.size(), 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (5000) @(posedge clk); check("watchdog", 1, 0); end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end
endmodule